// File: doc/BRIEF.md
# LED Matrix Column Scanner with Instruction Load

This block drives an LED matrix of 8 columns by 12 rows, lighting one column at a time. A processor fills an internal frame buffer by presenting a 20-bit instruction word together with a write strobe. Each instruction carries a 4-bit column code and 12 bits of row pattern. The code is offset by one, so code 0 is a no-op and code k writes column k-1. Codes above the column count, and the top four bits of the word, are ignored.

A free-running divider on the 50 MHz system clock produces a step every `STEP_CYCLES` clocks. The default of 2^15 gives a column rate of about 1526 Hz, about 0.66 ms per column and about 190 Hz for the full frame. On each step a column pointer advances through 0 to 7 and wraps. The block asserts the one-hot select for the current column and drives that column's stored row bits. An asynchronous reset clears the frame buffer, returns the pointer to column 0 and deasserts every column select.

Top module: `ledScanMux`

## Requirements
- R1: While `rstN` is low, `colSel` and `rows` are all zero. Right after reset is released, `colSel` is 8'b0000_0001 (column 0), and `rows` is zero because the frame buffer is cleared.
- R2: The column pointer advances exactly once every `STEP_CYCLES` rising clock edges. The first advance follows the `STEP_CYCLES`-th edge after reset is released.
- R3: Outside reset, `colSel` is one-hot and active high, with bit i selecting column i. It steps 0,1,...,7 and then wraps back to 0.
- R4: A rising edge with `wrEn` high and `instr[15:12]` equal to k, where 1 <= k <= 8, stores `instr[11:0]` as the row pattern of column k-1.
- R5: A write with `instr[15:12]` equal to 0 leaves the frame buffer unchanged.
- R6: A write with `instr[15:12]` from 9 to 15 leaves the frame buffer unchanged.
- R7: `instr[19:16]` has no effect on any write.
- R8: `rows` always shows the stored pattern of the column selected by `colSel`, with `rows[j]` being row j. A write to the displayed column appears on `rows` in the cycle after the write edge. A write to another column leaves `rows` unchanged.
- R9: While `wrEn` is low, `instr` has no effect on the frame buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz in the target system) |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for `instr`, sampled on the rising edge |
| instr | input | 20 | Load word: [19:16] ignored, [15:12] column code, [11:0] row pattern |
| colSel | output | 8 | One-hot column select, active high |
| rows | output | 12 | Row pattern of the selected column |

## Verification
A column change is due on the `STEP_CYCLES`-th rising edge after reset release, and then every `STEP_CYCLES` edges. A stored pattern reaches `rows` one edge after its write, or when its column is next selected. The bench uses a short step period and releases reset on a falling edge. It then counts exactly `STEP_CYCLES-1` and `STEP_CYCLES` edges and samples `colSel` at the falling edge on either side of the expected change. Each write is driven on a falling edge and its result is read at the next falling edge. Writes are timed just after a column change so that no step falls in between.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;

  // Strobes passed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic stepTick;   // advance the column pointer on this edge
    logic loadValid;  // store the decoded pattern on this edge
  } scanCtrl_t;

endpackage

// File: rtl/ledscan_ctrl.sv
module ledscan_ctrl
  import ledscan_pkg::*;
#(
  parameter int NUM_COLS    = 8,
  parameter int NUM_ROWS    = 12,
  parameter int INSTR_W     = 20,
  parameter int CODE_W      = 4,
  parameter int CODE_LSB    = 12,
  parameter int STEP_CYCLES = 32768,
  localparam int COL_W      = $clog2(NUM_COLS),
  localparam int DIV_W      = $clog2(STEP_CYCLES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [INSTR_W-1:0]  instr,
  output scanCtrl_t           ctrl,
  output logic [COL_W-1:0]    loadCol,
  output logic [NUM_ROWS-1:0] loadData
);

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CYCLES - 1);

  logic [DIV_W-1:0]  divCount;
  logic [CODE_W-1:0] colCode;
  logic [CODE_W-1:0] codeMinusOne;
  logic              codeInRange;

  // Free-running step divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCount <= '0;
    end else if (divCount == DIV_LAST) begin
      divCount <= '0;
    end else begin
      divCount <= divCount + 1'b1;
    end
  end

  // Instruction decode: code zero and codes past the last column are no-ops
  always_comb begin
    colCode      = instr[CODE_LSB +: CODE_W];
    codeMinusOne = colCode - CODE_W'(1);
    codeInRange  = (colCode != '0) && (int'(colCode) <= NUM_COLS);
    loadCol      = codeMinusOne[COL_W-1:0];
    loadData     = instr[NUM_ROWS-1:0];
  end

  always_comb begin
    ctrl.stepTick  = (divCount == DIV_LAST);
    ctrl.loadValid = wrEn && codeInRange;
  end

endmodule

// File: rtl/ledscan_dp.sv
module ledscan_dp
  import ledscan_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 12,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  scanCtrl_t           ctrl,
  input  logic [COL_W-1:0]    loadCol,
  input  logic [NUM_ROWS-1:0] loadData,
  output logic [NUM_COLS-1:0] colSel,
  output logic [NUM_ROWS-1:0] rows
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  logic [NUM_ROWS-1:0] frameMem [NUM_COLS];
  logic [COL_W-1:0]    colPtr;
  logic [NUM_COLS-1:0] colDecode;

  // Column pointer with wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colPtr <= '0;
    end else if (ctrl.stepTick) begin
      colPtr <= (colPtr == COL_LAST) ? '0 : colPtr + 1'b1;
    end
  end

  // Frame buffer, one register per column
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        frameMem[c] <= '0;
      end else if (ctrl.loadValid && (loadCol == COL_W'(c))) begin
        frameMem[c] <= loadData;
      end
    end
    assign colDecode[c] = (colPtr == COL_W'(c));
  end

  // Selects held low during reset; rows follow the current column
  always_comb begin
    colSel = rstN ? colDecode : '0;
    rows   = frameMem[colPtr];
  end

endmodule

// File: rtl/ledScanMux.sv
module ledScanMux
  import ledscan_pkg::*;
#(
  parameter int NUM_COLS    = 8,
  parameter int NUM_ROWS    = 12,
  parameter int INSTR_W     = 20,
  parameter int CODE_W      = 4,
  parameter int CODE_LSB    = 12,
  parameter int STEP_CYCLES = 32768
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [INSTR_W-1:0]  instr,
  output logic [NUM_COLS-1:0] colSel,
  output logic [NUM_ROWS-1:0] rows
);

  localparam int COL_W = $clog2(NUM_COLS);

  scanCtrl_t           ctrl;
  logic [COL_W-1:0]    loadCol;
  logic [NUM_ROWS-1:0] loadData;

  ledscan_ctrl #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .INSTR_W(INSTR_W),
    .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .STEP_CYCLES(STEP_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .instr(instr),
    .ctrl(ctrl), .loadCol(loadCol), .loadData(loadData)
  );

  ledscan_dp #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loadCol(loadCol),
    .loadData(loadData), .colSel(colSel), .rows(rows)
  );

endmodule

// File: rtl/ledScanMux_chk.sv
module ledScanMux_chk #(
  parameter int NUM_COLS    = 8,
  parameter int NUM_ROWS    = 12,
  parameter int INSTR_W     = 20,
  parameter int CODE_W      = 4,
  parameter int CODE_LSB    = 12,
  parameter int STEP_CYCLES = 32768
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [INSTR_W-1:0]  instr,
  input logic [NUM_COLS-1:0] colSel,
  input logic [NUM_ROWS-1:0] rows
);

  localparam int CW = $clog2(STEP_CYCLES + 1) + 1;

  logic [NUM_COLS-1:0] prevSel;
  logic [NUM_COLS-1:0] rotPrev;
  logic [NUM_COLS-1:0] targetMask;
  logic [CODE_W-1:0]   code;
  logic [CW-1:0]       sinceChg;
  logic                chg;
  logic                codeOk;
  logic                noStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel  <= NUM_COLS'(1);
      sinceChg <= '0;
    end else begin
      prevSel  <= colSel;
      sinceChg <= chg ? CW'(1) : sinceChg + 1'b1;
    end
  end

  always_comb begin
    chg        = (colSel != prevSel);
    rotPrev    = {prevSel[NUM_COLS-2:0], prevSel[NUM_COLS-1]};
    code       = instr[CODE_LSB +: CODE_W];
    codeOk     = (code != '0) && (int'(code) <= NUM_COLS);
    targetMask = codeOk ? (NUM_COLS'(1) << (code - CODE_W'(1))) : '0;
    noStep     = (sinceChg != CW'(STEP_CYCLES - 1));
  end

  // R1: outputs quiet while reset is held
  always_comb begin
    if (rstN == 1'b0) begin
      assert_reset_quiet_R1: assert (colSel == '0 && rows == '0);
    end
  end

  assert_step_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    chg |-> sinceChg == CW'(STEP_CYCLES));

  assert_step_due_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceChg == CW'(STEP_CYCLES)) |-> chg);

  assert_one_hot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(colSel) == 1);

  assert_rotate_R3: assert property (@(posedge clk) disable iff (!rstN)
    chg |-> colSel == rotPrev);

  assert_live_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && codeOk && (colSel == targetMask) && noStep
    |=> rows == $past(instr[NUM_ROWS-1:0]));

  assert_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && codeOk) && noStep |=> $stable(rows));

  assert_other_col_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && codeOk && (colSel != targetMask) && noStep |=> $stable(rows));

endmodule

bind ledScanMux ledScanMux_chk #(
  .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .INSTR_W(INSTR_W),
  .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .STEP_CYCLES(STEP_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .instr(instr),
  .colSel(colSel), .rows(rows)
);

// File: tb/tb_ledScanMux.sv
module tb_ledScanMux;

  localparam int NC   = 8;
  localparam int NR   = 12;
  localparam int STEP = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [19:0]   instr = '0;
  logic [NC-1:0] colSel;
  logic [NR-1:0] rows;

  logic [NR-1:0] model [NC];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ledScanMux #(.STEP_CYCLES(STEP)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .instr(instr),
    .colSel(colSel), .rows(rows)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Wait, at falling edges, until column c is selected
  task automatic waitForCol(input int c);
    for (int i = 0; i < 4 * NC * STEP; i++) begin
      @(negedge clk);
      if (colSel == NC'(1) << c) return;
    end
    check("R3 waitForCol", 32'(colSel), 32'(NC'(1) << c));
  endtask

  task automatic writeInstr(input logic [19:0] w, input logic en);
    instr = w;
    wrEn  = en;
    @(negedge clk);
    wrEn  = 1'b0;
    instr = '0;
  endtask

  task automatic testReset();
    for (int c = 0; c < NC; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    check("R1 colSel in reset", 32'(colSel), 32'h0);
    check("R1 rows in reset", 32'(rows), 32'h0);
    rstN = 1'b1;
    #1;
    check("R1 colSel after release", 32'(colSel), 32'h1);
    check("R1 rows after release", 32'(rows), 32'h0);
  endtask

  task automatic testStepTiming();
    repeat (STEP - 1) @(negedge clk);
    check("R2 still col0 before first step", 32'(colSel), 32'h1);
    @(negedge clk);
    check("R2 first step to col1", 32'(colSel), 32'h2);
    repeat (STEP - 1) @(negedge clk);
    check("R2 still col1", 32'(colSel), 32'h2);
    @(negedge clk);
    check("R2 second step to col2", 32'(colSel), 32'h4);
  endtask

  task automatic testSequence();
    logic [NC-1:0] expSel;
    waitForCol(0);
    expSel = NC'(1);
    for (int s = 0; s < NC + 2; s++) begin
      repeat (STEP) @(negedge clk);
      expSel = {expSel[NC-2:0], expSel[NC-1]};
      check("R3 column order with wrap", 32'(colSel), 32'(expSel));
    end
  endtask

  task automatic scanCompare(input string req);
    for (int c = 0; c < NC; c++) begin
      waitForCol(c);
      check(req, 32'(rows), 32'(model[c]));
    end
  endtask

  task automatic testLoadAll();
    for (int c = 0; c < NC; c++) begin
      logic [NR-1:0] pat = NR'(12'h5A3 ^ (c * 12'h111));
      logic [3:0]    junk = 4'(4'hF - c);
      writeInstr({junk, 4'(c + 1), pat}, 1'b1);
      model[c] = pat;
    end
    scanCompare("R4 R7 code k loads column k-1");
  endtask

  task automatic testIgnored();
    writeInstr({4'h0, 4'h0, 12'hFFF}, 1'b1);
    for (int k = 9; k < 16; k++) writeInstr({4'hA, 4'(k), 12'h000}, 1'b1);
    scanCompare("R5 R6 code 0 and 9..15 ignored");
    writeInstr({4'h0, 4'h1, 12'h0F0}, 1'b0);
    writeInstr({4'h0, 4'h8, 12'h0F0}, 1'b0);
    scanCompare("R9 no write while wrEn low");
  endtask

  task automatic testLive();
    waitForCol(3);
    writeInstr({4'h0, 4'h4, 12'hC3C}, 1'b1);
    model[3] = 12'hC3C;
    check("R8 live write shows next cycle", 32'(rows), 32'hC3C);
    writeInstr({4'h0, 4'h1, 12'h777}, 1'b1);
    model[0] = 12'h777;
    check("R8 write to other column leaves rows", 32'(rows), 32'hC3C);
    waitForCol(0);
    check("R8 column 0 shows its new pattern", 32'(rows), 32'h777);
  endtask

  initial begin
    testReset();
    testStepTiming();
    testSequence();
    testLoadAll();
    testIgnored();
    testLive();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

endmodule